// File: doc/BRIEF.md
# Interrupt Status and Gating Unit

This block collects the event pulses of an SD host controller and turns them into one level-sensitive interrupt line. The events come from the command sequencer (command finished, no response, automatic stop finished), the data path (transfer finished, card-side interrupt) and the card-detect logic (card inserted, card removed). Each event latches a bit in a raw status register. A mask register selects which latched bits may reach the interrupt line, and an enable bit in a control register gates that line as a whole.

Software reaches the block through a small register port with a combinational read path. It can read the raw status or a masked view of it. It clears raw bits by writing ones to either address. A separate status register holds a card-present flag that follows the card-detect events, and software can also clear that flag by writing a one to it.

Top module: `isr_unit`

## Requirements
- R1: Event pulses set raw status bits on the next clock edge: command done at bit 2, no response at bit 1, data done at bit 3, automatic stop done at bit 14, card-side interrupt at bit 16. All other raw bits except 30 and 31 always read 0.
- R2: A read at the masked-status select (2) returns the raw status ANDed with the mask register.
- R3: A write at the raw-status select (3) or the masked-status select (2) clears every raw bit whose written bit is 1 and leaves the bits written as 0 unchanged.
- R4: When a set event and a software clear reach the same raw bit in one cycle, the bit ends up set.
- R5: A card insert pulse sets raw bit 30, clears raw bit 31 and sets the card-present flag. A card remove pulse sets bit 31, clears bit 30 and clears the flag. If both pulse in the same cycle, the removal wins. Bits 30 and 31 are never both set.
- R6: The status register (select 4) reads the card-present flag at bit 8 and 0 elsewhere. Writing a 1 to bit 8 clears the flag, unless a card event in the same cycle sets or clears it.
- R7: The interrupt output is registered. It equals, one cycle late, the OR over all bits of raw status AND mask, qualified by the enable bit.
- R8: While the enable bit (control select 0, bit 4) is 0, the interrupt output is low from the next cycle onward, whatever the status and mask hold.
- R9: After a synchronous active-low reset, the raw status, the mask, the control register and the interrupt output are 0, and the status register reads 0x100.
- R10: The control register reads back only bit 4. The mask register (select 1) stores and reads back all 32 bits. Selects 5 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_cmd_done | input | 1 | Command finished pulse |
| ev_no_resp | input | 1 | Command got no valid response pulse |
| ev_data_done | input | 1 | Data transfer finished pulse |
| ev_auto_done | input | 1 | Automatic stop command finished pulse |
| ev_sdio | input | 1 | Card-side interrupt pulse |
| cd_insert | input | 1 | Card inserted pulse |
| cd_remove | input | 1 | Card removed pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 mask, 2 masked status, 3 raw status, 4 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Level interrupt output |

## Verification
The bench aims at cycles where a hardware event and a software clear hit the same bit. A design that applies the clear last would drop the event and lose the interrupt. It pulses insert and remove together and one after the other. A wrong priority would leave both card bits set or report a card present that has gone. It writes ones through the masked address to bits that are masked off. A design that clears only the visible bits would keep stale status there. It toggles the enable and the mask while status is pending and checks the output one cycle later. A combinational or ungated output would show up as an edge that comes too early or as an interrupt that should be blocked.

// File: rtl/isr_pkg.sv
// Package: shared constants and select codes for the interrupt status unit.
// Assumes a 32-bit register port; bit positions are fixed by software decode.
package isr_pkg;

    localparam int DW = 32;

    // raw status bit positions (decoded by software, so fixed)
    localparam int B_NO_RESP   = 1;
    localparam int B_CMD_DONE  = 2;
    localparam int B_DATA_DONE = 3;
    localparam int B_AUTO_DONE = 14;
    localparam int B_SDIO      = 16;
    localparam int B_CARD_IN   = 30;
    localparam int B_CARD_OUT  = 31;

    // status register card-present position and control enable position
    localparam int B_PRESENT   = 8;
    localparam int B_IRQ_EN    = 4;

    localparam logic [DW-1:0] RAW_IMPL =
        (DW'(1) << B_NO_RESP)  | (DW'(1) << B_CMD_DONE) |
        (DW'(1) << B_DATA_DONE)| (DW'(1) << B_AUTO_DONE)|
        (DW'(1) << B_SDIO)     | (DW'(1) << B_CARD_IN)  |
        (DW'(1) << B_CARD_OUT);

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL   = 3'd0,
        SEL_MASK   = 3'd1,
        SEL_MSTAT  = 3'd2,
        SEL_RSTAT  = 3'd3,
        SEL_STATUS = 3'd4
    } isr_sel_e;

endpackage

// File: rtl/isr_raw_status.sv
// Module: raw status register plus card-present flag.
// Merges hardware set pulses with software write-one-to-clear; a set always
// beats a clear of the same bit. Card insert/remove kill each other's bit.
// Assumes the caller has already resolved insert-vs-remove in one cycle.
module isr_raw_status
    import isr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] set_vec,
    input  logic          card_in,
    input  logic          card_out,
    input  logic [DW-1:0] sw_clr,
    input  logic          sw_clr_present,
    output logic [DW-1:0] raw_q,
    output logic          present_q
);

    logic [DW-1:0] card_kill;
    logic [DW-1:0] raw_d;
    logic          present_d;

    // Purpose: bits forced low by the opposite card event
    always_comb begin
        card_kill = '0;
        card_kill[B_CARD_OUT] = card_in;
        card_kill[B_CARD_IN]  = card_out;
    end

    // Purpose: next raw value, clear first then set so the set wins
    always_comb begin
        raw_d = ((raw_q & ~sw_clr & ~card_kill) | set_vec) & RAW_IMPL;
    end

    // Purpose: next card-present flag, card events override software clear
    always_comb begin
        if (card_out)
            present_d = 1'b0;
        else if (card_in)
            present_d = 1'b1;
        else if (sw_clr_present)
            present_d = 1'b0;
        else
            present_d = present_q;
    end

    // Purpose: state registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q     <= '0;
            present_q <= 1'b1;
        end else begin
            raw_q     <= raw_d;
            present_q <= present_d;
        end
    end

endmodule

// File: rtl/isr_mask_ctl.sv
// Module: interrupt mask register and global enable bit.
// Assumes write strobes are already decoded from the select code.
module isr_mask_ctl
    import isr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_we,
    input  logic          en_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mask_q,
    output logic          en_q
);

    // Purpose: hold mask and enable, load on their write strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            en_q   <= 1'b0;
        end else begin
            if (mask_we)
                mask_q <= wdata;
            if (en_we)
                en_q <= wdata[B_IRQ_EN];
        end
    end

endmodule

// File: rtl/isr_irq_gate.sv
// Module: masked status view and registered, enable-gated interrupt line.
// Assumes one cycle of output latency is acceptable to the interrupt fabric.
module isr_irq_gate
    import isr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] raw,
    input  logic [DW-1:0] mask,
    input  logic          en,
    output logic [DW-1:0] masked,
    output logic          irq_q
);

    // Purpose: masked status as seen by software
    always_comb begin
        masked = raw & mask;
    end

    // Purpose: register the gated OR so the output is glitch free
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= en & (|masked);
    end

endmodule

// File: rtl/isr_unit.sv
// Module: top of the interrupt status unit.
// Decodes the register port, builds the event set vector, resolves the
// insert/remove collision (removal wins) and muxes read data.
// Assumes event inputs are single-cycle pulses synchronous to clk.
module isr_unit
    import isr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_cmd_done,
    input  logic        ev_no_resp,
    input  logic        ev_data_done,
    input  logic        ev_auto_done,
    input  logic        ev_sdio,
    input  logic        cd_insert,
    input  logic        cd_remove,
    input  logic        reg_wr,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);

    isr_sel_e      sel;
    logic          ins_eff;
    logic [DW-1:0] set_vec;
    logic [DW-1:0] sw_clr;
    logic          sw_clr_present;
    logic [DW-1:0] raw_q;
    logic          present_q;
    logic [DW-1:0] mask_q;
    logic          en_q;
    logic [DW-1:0] masked;

    // Purpose: typed view of the select code
    always_comb sel = isr_sel_e'(reg_sel);

    // Purpose: removal beats insertion within one cycle
    always_comb ins_eff = cd_insert & ~cd_remove;

    // Purpose: gather event pulses into the raw bit layout
    always_comb begin
        set_vec = '0;
        set_vec[B_NO_RESP]   = ev_no_resp;
        set_vec[B_CMD_DONE]  = ev_cmd_done;
        set_vec[B_DATA_DONE] = ev_data_done;
        set_vec[B_AUTO_DONE] = ev_auto_done;
        set_vec[B_SDIO]      = ev_sdio;
        set_vec[B_CARD_IN]   = ins_eff;
        set_vec[B_CARD_OUT]  = cd_remove;
    end

    // Purpose: software clear requests from both status addresses
    always_comb begin
        sw_clr         = (reg_wr && (sel == SEL_RSTAT || sel == SEL_MSTAT)) ? reg_wdata : '0;
        sw_clr_present = reg_wr && (sel == SEL_STATUS) && reg_wdata[B_PRESENT];
    end

    isr_raw_status u_raw (
        .clk            (clk),
        .rst_n          (rst_n),
        .set_vec        (set_vec),
        .card_in        (ins_eff),
        .card_out       (cd_remove),
        .sw_clr         (sw_clr),
        .sw_clr_present (sw_clr_present),
        .raw_q          (raw_q),
        .present_q      (present_q)
    );

    isr_mask_ctl u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (reg_wr && sel == SEL_MASK),
        .en_we   (reg_wr && sel == SEL_CTRL),
        .wdata   (reg_wdata),
        .mask_q  (mask_q),
        .en_q    (en_q)
    );

    isr_irq_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw_q),
        .mask   (mask_q),
        .en     (en_q),
        .masked (masked),
        .irq_q  (irq)
    );

    // Purpose: combinational read mux
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_CTRL:   reg_rdata[B_IRQ_EN]  = en_q;
            SEL_MASK:   reg_rdata            = mask_q;
            SEL_MSTAT:  reg_rdata            = masked;
            SEL_RSTAT:  reg_rdata            = raw_q;
            SEL_STATUS: reg_rdata[B_PRESENT] = present_q;
            default:    reg_rdata            = '0;
        endcase
    end

endmodule

// File: rtl/isr_unit_chk.sv
// Module: assertion checker for isr_unit, attached by bind below.
// Assumes reset is held low for at least two clock edges at start.
module isr_unit_chk
    import isr_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          ev_cmd_done,
    input logic          ev_no_resp,
    input logic          ev_data_done,
    input logic          ev_auto_done,
    input logic          ev_sdio,
    input logic          cd_insert,
    input logic          cd_remove,
    input logic          reg_wr,
    input logic [2:0]    reg_sel,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] raw,
    input logic [DW-1:0] mask,
    input logic          en,
    input logic          present,
    input logic          irq
);

    logic quiet;
    always_comb quiet = !(ev_cmd_done || ev_no_resp || ev_data_done ||
                          ev_auto_done || ev_sdio || cd_insert || cd_remove);

    p_cmd_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cmd_done |=> raw[B_CMD_DONE]);

    p_sdio_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sdio |=> raw[B_SDIO]);

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_sel == 3'd2 || reg_sel == 3'd3) && quiet)
        |=> ((raw & $past(reg_wdata)) == '0));

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_data_done && reg_wr && reg_sel == 3'd3 && reg_wdata[B_DATA_DONE])
        |=> raw[B_DATA_DONE]);

    p_card_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(raw[B_CARD_IN] && raw[B_CARD_OUT]));

    p_insert_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_insert && !cd_remove) |=> (raw[B_CARD_IN] && !raw[B_CARD_OUT] && present));

    p_remove_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cd_remove |=> (raw[B_CARD_OUT] && !raw[B_CARD_IN] && !present));

    p_irq_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(en && (|(raw & mask))));

    p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !irq);

endmodule

bind isr_unit isr_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_cmd_done  (ev_cmd_done),
    .ev_no_resp   (ev_no_resp),
    .ev_data_done (ev_data_done),
    .ev_auto_done (ev_auto_done),
    .ev_sdio      (ev_sdio),
    .cd_insert    (cd_insert),
    .cd_remove    (cd_remove),
    .reg_wr       (reg_wr),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .raw          (raw_q),
    .mask         (mask_q),
    .en           (en_q),
    .present      (present_q),
    .irq          (irq)
);

// File: tb/isr_unit_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model stepped each clock and compared
// against every readable register and the interrupt line.
module isr_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_cmd_done = 0, ev_no_resp = 0, ev_data_done = 0;
    logic        ev_auto_done = 0, ev_sdio = 0, cd_insert = 0, cd_remove = 0;
    logic        reg_wr = 0;
    logic [2:0]  reg_sel = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    string tag = "R9";

    // reference model state
    logic [31:0] m_raw, m_mask;
    logic        m_en, m_present, m_irq;

    always #2.5 clk = ~clk;

    isr_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .ev_cmd_done(ev_cmd_done), .ev_no_resp(ev_no_resp),
        .ev_data_done(ev_data_done), .ev_auto_done(ev_auto_done),
        .ev_sdio(ev_sdio), .cd_insert(cd_insert), .cd_remove(cd_remove),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] model_read(input int s);
        case (s)
            0: return m_en ? 32'h10 : 32'h0;
            1: return m_mask;
            2: return m_raw & m_mask;
            3: return m_raw;
            4: return m_present ? 32'h100 : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string sel_tag(input int s);
        case (s)
            0: return "R10";
            1: return "R10";
            2: return "R2";
            3: return "R3";
            4: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic check_all();
        for (int s = 0; s < 6; s++) begin
            reg_sel = 3'(s);
            #0.2;
            total++;
            if (reg_rdata !== model_read(s)) begin
                bad++;
                $display("FAIL %s/%s sel=%0d actual=%h expected=%h",
                         tag, sel_tag(s), s, reg_rdata, model_read(s));
            end
        end
        total++;
        if (irq !== m_irq) begin
            bad++;
            $display("FAIL %s/R7 irq actual=%b expected=%b", tag, irq, m_irq);
        end
    endtask

    // ev bits: 0 cmd, 1 no_resp, 2 data, 3 auto, 4 sdio, 5 insert, 6 remove
    task automatic step(input logic [6:0] ev, input logic wr,
                        input logic [2:0] sel, input logic [31:0] wd);
        logic [31:0] setv, clr;
        logic        ins;
        ev_cmd_done = ev[0]; ev_no_resp = ev[1]; ev_data_done = ev[2];
        ev_auto_done = ev[3]; ev_sdio = ev[4]; cd_insert = ev[5]; cd_remove = ev[6];
        reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        @(posedge clk);
        m_irq = m_en && ((m_raw & m_mask) != 0);
        ins  = ev[5] && !ev[6];
        setv = 0;
        if (ev[0]) setv[2]  = 1;
        if (ev[1]) setv[1]  = 1;
        if (ev[2]) setv[3]  = 1;
        if (ev[3]) setv[14] = 1;
        if (ev[4]) setv[16] = 1;
        if (ins)   setv[30] = 1;
        if (ev[6]) setv[31] = 1;
        clr = (wr && (sel == 2 || sel == 3)) ? wd : 0;
        if (ins)   clr[31] = 1;
        if (ev[6]) clr[30] = 1;
        m_raw = (m_raw & ~clr) | setv;
        if (wr && sel == 1) m_mask = wd;
        if (wr && sel == 0) m_en = wd[4];
        if (ev[6]) m_present = 0;
        else if (ins) m_present = 1;
        else if (wr && sel == 4 && wd[8]) m_present = 0;
        @(negedge clk);
        {ev_cmd_done, ev_no_resp, ev_data_done, ev_auto_done, ev_sdio,
         cd_insert, cd_remove} = '0;
        reg_wr = 0;
        check_all();
    endtask

    task automatic idle(); step(7'h0, 0, 0, 0); endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lfsr;
        m_raw = 0; m_mask = 0; m_en = 0; m_present = 1; m_irq = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R9: reset values
        tag = "R9"; check_all();

        // R1: each event alone sets its bit
        tag = "R1";
        step(7'h01, 0, 0, 0); step(7'h02, 0, 0, 0); step(7'h04, 0, 0, 0);
        step(7'h08, 0, 0, 0); step(7'h10, 0, 0, 0);

        // R2: masked view with partial mask
        tag = "R2";
        step(7'h0, 1, 1, 32'h0000_400C); idle();

        // R8: enable off keeps irq low despite pending masked status
        tag = "R8";
        idle(); idle();
        // R7: enable on, irq follows one cycle later
        tag = "R7";
        step(7'h0, 1, 0, 32'hFFFF_FFFF); idle(); idle();
        // R8: enable off again
        tag = "R8";
        step(7'h0, 1, 0, 32'h0); idle();
        tag = "R7";
        step(7'h0, 1, 0, 32'h10); idle();

        // R3: clear through raw address, zeros leave bits
        tag = "R3";
        step(7'h0, 1, 3, 32'h0000_0004); idle();
        // R3: clear masked-off bit through masked address
        step(7'h0, 1, 2, 32'h0001_0000); idle();
        step(7'h0, 1, 2, 32'hFFFF_FFFF); idle();

        // R4: set and clear same bit same cycle
        tag = "R4";
        step(7'h04, 1, 3, 32'h0000_0008); idle();
        step(7'h01, 1, 2, 32'hFFFF_FFFF); idle();

        // R5: card events
        tag = "R5";
        step(7'h40, 0, 0, 0); idle();
        step(7'h20, 0, 0, 0); step(7'h20, 0, 0, 0);
        step(7'h60, 0, 0, 0); idle();
        step(7'h20, 1, 3, 32'h4000_0000); idle();

        // R6: status write clears present; card event same cycle wins
        tag = "R6";
        step(7'h0, 1, 4, 32'h0000_0100); idle();
        step(7'h20, 1, 4, 32'h0000_0100); idle();
        step(7'h0, 1, 4, 32'hFFFF_FEFF); idle();

        // R10: control reads only bit 4; unused selects ignored
        tag = "R10";
        step(7'h0, 1, 0, 32'hFFFF_FFEF); step(7'h0, 1, 0, 32'hFFFF_FFFF);
        step(7'h0, 1, 5, 32'hFFFF_FFFF); step(7'h0, 1, 7, 32'hFFFF_FFFF);
        step(7'h0, 1, 1, 32'hA5A5_5A5A); idle();

        // R7: pseudo-random mix of events and writes
        tag = "R7";
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(7'(lfsr[6:0] & {lfsr[9], 6'h3F}), lfsr[11], 3'(lfsr[14:12] % 5),
                 {lfsr, lfsr[7:0], lfsr[15:8]});
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule